// File: doc/BRIEF.md
# External Bus Hold Arbiter

This block lets an outside bus master borrow a microcontroller's external bus. A control bit allows the feature. An active-high request pin asks for the bus. While the device is awake, the block looks at the request only when the CPU signals that an instruction has just finished. When it grants a request, it first stalls the CPU and turns off the output enables of the upper address pins, the multiplexed address/data pins and the bus strobe pins. One idle cycle follows. Only after that idle cycle does the active-low acknowledge go low.

When the outside master drops its request, the acknowledge returns high first. A second idle cycle follows, and then the pin drivers and the CPU are released. For the whole time the CPU is stalled, the watchdog clear output is held high so that the watchdog cannot fire during a long hold. On-chip peripherals run on and are not touched by this block.

Top module: `bus_hold_ctrl`

## Requirements
- R1: When `hold_en_i` is 0 in the idle state, a high request never starts a hold: acknowledge stays 1, stall stays 0 and all output enables stay 1.
- R2: A request is taken only on a clock edge where `insn_bound_i` is 1. A request held high while the strobe is low leaves the block idle.
- R3: On a grant, `cpu_stall_o` goes to 1 and every bit of `addr_hi_oe_o`, `addr_data_oe_o` and `strobe_oe_o` goes to 0 in the same cycle. At that point `hold_ack_no` is still 1.
- R4: Exactly one clock cycle after the enables drop, `hold_ack_no` goes to 0. It stays 0 while the synchronized request stays high.
- R5: After the synchronized request falls, `hold_ack_no` returns to 1 while stall stays 1 and the enables stay 0 for exactly one cycle. After that cycle, stall returns to 0 and all enables return to 1.
- R6: While `sleep_i` or `stop_i` is 1, a request at an instruction boundary is not taken.
- R7: `wdt_clr_o` is 1 in every cycle in which `cpu_stall_o` is 1, and 0 when idle.
- R8: If the request falls during the first idle cycle, `hold_ack_no` is still driven 0 for one cycle before the release sequence of R5.
- R9: Clearing `hold_en_i` while the acknowledge is low does not end the hold. Only a low request does.
- R10: While `rst_ni` is 0, and after reset, the outputs are: acknowledge 1, stall 0, watchdog clear 0, all enables 1.
- R11: The request passes through a two-flop synchronizer. A request that rises before edge k, with the boundary strobe held at 1, causes the grant of R3 to appear after edge k+2 and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hold_en_i | input | 1 | Hold feature enable from the control register |
| hold_req_i | input | 1 | Asynchronous bus request, active high |
| insn_bound_i | input | 1 | High in cycles that end an instruction |
| sleep_i | input | 1 | Device is in sleep mode |
| stop_i | input | 1 | Device is in stop mode |
| hold_ack_no | output | 1 | Bus released acknowledge, active low |
| cpu_stall_o | output | 1 | Freezes the CPU |
| addr_hi_oe_o | output | ADDR_HI_W | Upper address pin output enables |
| addr_data_oe_o | output | AD_W | Multiplexed address/data pin output enables |
| strobe_oe_o | output | N_STROBE | Read, write, ready and buffer-control pin enables |
| wdt_clr_o | output | 1 | Holds the watchdog counter cleared |

## Verification
A wrong state register shows up at the ports within one cycle. Acknowledge, stall and the enables are decoded straight from the state, so a skipped or stretched idle cycle changes the cycle in which the acknowledge falls or the enables come back, measured from the edge that sampled the request. A gating fault (enable, boundary, sleep or stop) shows up three edges after the request rises, as a stall that should not be there. A synchronizer of the wrong depth moves that first stall by one cycle.

// File: rtl/bus_hold_pkg.sv
package bus_hold_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_FLOAT    = 2'd1,
    ST_HOLD     = 2'd2,
    ST_RESTORE  = 2'd3
  } hold_state_e;
endpackage

// File: rtl/bus_hold_sync.sv
module bus_hold_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/bus_hold_fsm.sv
module bus_hold_fsm
  import bus_hold_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        en_i,
  input  logic        bound_i,
  input  logic        sleep_i,
  input  logic        stop_i,
  output hold_state_e state_o
);
  hold_state_e state_q, state_d;
  logic        take;

  assign take = req_i && en_i && bound_i && !sleep_i && !stop_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (take) state_d = ST_FLOAT;
      ST_FLOAT:   state_d = ST_HOLD;      // ack always shown once
      ST_HOLD:    if (!req_i) state_d = ST_RESTORE;
      ST_RESTORE: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;

  assign state_o = state_q;

  AST_ENTRY_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !(req_i && en_i && bound_i && !sleep_i && !stop_i)) |=> state_q == ST_IDLE); // R1 R2 R6
  AST_FLOAT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_FLOAT |=> state_q == ST_HOLD); // R8
  AST_HOLD_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && req_i) |=> state_q == ST_HOLD); // R9
  AST_RESTORE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_RESTORE |=> state_q == ST_IDLE); // R5
endmodule

// File: rtl/bus_hold_outdrv.sv
module bus_hold_outdrv
  import bus_hold_pkg::*;
#(
  parameter int unsigned ADDR_HI_W = 8,
  parameter int unsigned AD_W      = 8,
  parameter int unsigned N_STROBE  = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  hold_state_e          state_i,
  output logic                 ack_no,
  output logic                 stall_o,
  output logic [ADDR_HI_W-1:0] addr_hi_oe_o,
  output logic [AD_W-1:0]      addr_data_oe_o,
  output logic [N_STROBE-1:0]  strobe_oe_o,
  output logic                 wdt_clr_o
);
  localparam int unsigned OE_W = ADDR_HI_W + AD_W + N_STROBE;

  logic            drive;
  logic [OE_W-1:0] oe_all;

  assign drive     = (state_i == ST_IDLE);
  assign stall_o   = !drive;
  assign wdt_clr_o = !drive;
  assign ack_no    = (state_i != ST_HOLD);

  genvar g;
  generate
    for (g = 0; g < OE_W; g++) begin : g_oe
      assign oe_all[g] = drive;
    end
  endgenerate

  assign {addr_hi_oe_o, addr_data_oe_o, strobe_oe_o} = oe_all;

  AST_ACK_AFTER_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_no) |-> ($past(stall_o) && $past(oe_all) == '0 && $past(ack_no))); // R4
  AST_ACK_BUS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_no |-> (stall_o && oe_all == '0)); // R3
  AST_RESTORE_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_all[0]) |-> ($past(ack_no) && $past(stall_o))); // R5
  AST_WDT_DURING_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> wdt_clr_o); // R7
endmodule

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl
  import bus_hold_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_HI_W   = 8,
  parameter int unsigned AD_W        = 8,
  parameter int unsigned N_STROBE    = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 hold_en_i,
  input  logic                 hold_req_i,
  input  logic                 insn_bound_i,
  input  logic                 sleep_i,
  input  logic                 stop_i,
  output logic                 hold_ack_no,
  output logic                 cpu_stall_o,
  output logic [ADDR_HI_W-1:0] addr_hi_oe_o,
  output logic [AD_W-1:0]      addr_data_oe_o,
  output logic [N_STROBE-1:0]  strobe_oe_o,
  output logic                 wdt_clr_o
);
  logic        req_sync;
  hold_state_e state;

  bus_hold_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (hold_req_i),
    .q_o   (req_sync)
  );

  bus_hold_fsm u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_sync),
    .en_i   (hold_en_i),
    .bound_i(insn_bound_i),
    .sleep_i(sleep_i),
    .stop_i (stop_i),
    .state_o(state)
  );

  bus_hold_outdrv #(
    .ADDR_HI_W(ADDR_HI_W),
    .AD_W     (AD_W),
    .N_STROBE (N_STROBE)
  ) u_out (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .state_i       (state),
    .ack_no        (hold_ack_no),
    .stall_o       (cpu_stall_o),
    .addr_hi_oe_o  (addr_hi_oe_o),
    .addr_data_oe_o(addr_data_oe_o),
    .strobe_oe_o   (strobe_oe_o),
    .wdt_clr_o     (wdt_clr_o)
  );

  AST_STALL_NEEDS_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_stall_o) |-> ($past(req_sync) && $past(hold_en_i) && $past(insn_bound_i)
                            && !$past(sleep_i) && !$past(stop_i))); // R1 R2 R6
endmodule

// File: tb/bus_hold_ctrl_test.sv
module bus_hold_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, req = 1'b0, bnd = 1'b0, slp = 1'b0, stp = 1'b0;
  logic ack_n, stall, wdt;
  logic [7:0] a_oe, ad_oe;
  logic [3:0] s_oe;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  bus_hold_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .hold_en_i(en), .hold_req_i(req),
    .insn_bound_i(bnd), .sleep_i(slp), .stop_i(stp),
    .hold_ack_no(ack_n), .cpu_stall_o(stall), .addr_hi_oe_o(a_oe),
    .addr_data_oe_o(ad_oe), .strobe_oe_o(s_oe), .wdt_clr_o(wdt)
  );

  // {en, req, bnd, slp, stp, exp_ack_n, exp_stall}
  localparam int NV = 10;
  localparam logic [6:0] VEC [NV] = '{
    7'b1_0_1_0_0_1_0,
    7'b0_1_1_0_0_1_0,
    7'b1_1_1_1_0_1_0,
    7'b1_1_1_0_1_1_0,
    7'b1_1_0_0_0_1_0,
    7'b1_1_1_0_0_0_1,
    7'b0_1_1_0_0_0_1,
    7'b1_0_1_0_0_1_0,
    7'b1_1_1_0_0_0_1,
    7'b1_0_0_0_0_1_0
  };

  function automatic string vtag(int i);
    case (i)
      1: return "R1";
      2, 3: return "R6";
      4: return "R2";
      5, 8: return "R3";
      6: return "R9";
      7, 9: return "R5";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // {all enables on, any enable on}
  function automatic logic [1:0] oe_sum();
    return {&{a_oe, ad_oe, s_oe}, |{a_oe, ad_oe, s_oe}};
  endfunction

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_chk(string tag);
    chk(tag, {ack_n, stall, wdt}, 3'b100);
    chk(tag, oe_sum(), 2'b11);
  endtask

  initial begin
    #1_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    req = 1'b1; en = 1'b1; bnd = 1'b1;
    tick(3);
    idle_chk("R10 in reset");
    req = 1'b0;
    tick(4);
    rst_n = 1'b1;
    tick(2);
    idle_chk("R10 after reset");

    for (int i = 0; i < NV; i++) begin
      {en, req, bnd, slp, stp} = VEC[i][6:2];
      tick(6);
      chk({vtag(i), " ack/stall"}, {ack_n, stall}, VEC[i][1:0]);
      chk({vtag(i), " oe"}, oe_sum(), VEC[i][0] ? 2'b00 : 2'b11);
      chk("R7 wdt", wdt, VEC[i][0]);
    end
    {en, req, bnd, slp, stp} = 5'b10100;
    tick(6);

    // exact grant/release timing, inputs changed at the falling edge
    req = 1'b1;
    tick(2);
    idle_chk("R11 not before edge k+2");
    tick(1);
    chk("R3 grant stall/ack", {ack_n, stall, wdt}, 3'b111);
    chk("R3 grant oe", oe_sum(), 2'b00);
    tick(1);
    chk("R4 ack low after dead", {ack_n, stall}, 2'b01);
    tick(3);
    chk("R4 ack held", ack_n, 1'b0);
    req = 1'b0;
    tick(2);
    chk("R5 hold until sync", ack_n, 1'b0);
    tick(1);
    chk("R5 ack high first", {ack_n, stall}, 2'b11);
    chk("R5 oe still off", oe_sum(), 2'b00);
    tick(1);
    idle_chk("R5 restored");

    // request dropped during the first dead cycle
    tick(4);
    req = 1'b1;
    tick(1);
    req = 1'b0;
    tick(2);
    chk("R8 float", {ack_n, stall}, 2'b11);
    tick(1);
    chk("R8 ack shown", {ack_n, stall}, 2'b01);
    tick(1);
    chk("R8 release dead", {ack_n, stall}, 2'b11);
    tick(1);
    idle_chk("R8 back idle");

    // boundary strobe: pending request waits, single strobe takes it
    bnd = 1'b0; req = 1'b1;
    tick(8);
    idle_chk("R2 waits for boundary");
    bnd = 1'b1;
    tick(1);
    bnd = 1'b0;
    chk("R2 taken on strobe", stall, 1'b1);
    tick(1);
    chk("R2 ack", ack_n, 1'b0);

    // enable cleared in hold
    en = 1'b0;
    tick(5);
    chk("R9 hold kept", {ack_n, stall}, 2'b01);
    req = 1'b0;
    tick(4);
    idle_chk("R9 released by request");
    tick(2);
    chk("R1 disabled no grant", stall, 1'b0);

    // reset during hold
    en = 1'b1; bnd = 1'b1; req = 1'b1;
    tick(5);
    chk("R10 pre-reset hold", ack_n, 1'b0);
    rst_n = 1'b0;
    #1;
    idle_chk("R10 async reset");
    tick(1);
    req = 1'b0;
    rst_n = 1'b1;
    tick(3);
    idle_chk("R10 post reset");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule